// File: doc/BRIEF.md
# Window Watchdog with Asymmetric Failure Counter

This block supervises a periodic service signal from a controller through a window watchdog. Every period begins with a closed window, in which servicing is forbidden, followed by an open window, in which it is expected. Both windows have programmable lengths measured in timer ticks. Each period ends with exactly one verdict. A trigger strobe inside the open window is valid. A trigger inside the closed window is invalid, and so is an open window that runs out without a trigger.

The verdicts drive a saturating failure counter. The counter climbs by two on every invalid verdict and sinks by one on every valid verdict. A controller that services the watchdog correctly most of the time therefore keeps the count low, and only a sustained run of bad servicing pushes it up. An update that leaves the count above a programmable limit sets a sticky overflow flag, which serves as the safe-state request. The flag stays set until it is cleared explicitly. Command decoding for the service interface lies outside this block: trigger and configuration arrive as plain inputs.

Top module: `win_watchdog`

## Requirements
- R1: While reset is asserted and on the first cycle after it, fail_count is 0, ovf_flag is 0 and neither event pulse is high.
- R2: A period spends max(closed_len,1) ticks in the closed window and then max(open_len,1) ticks in the open window. If the last open tick arrives without a trigger, invalid_pulse is high in the cycle after that tick and a new closed window begins. With a tick every cycle and no trigger, invalid pulses therefore come every max(closed_len,1)+max(open_len,1) cycles.
- R3: A trigger during the closed window gives invalid_pulse in the next cycle and restarts the closed window from zero.
- R4: A trigger during the open window gives valid_pulse in the next cycle and at once starts a new closed window.
- R5: Each invalid verdict adds 2 to fail_count, which saturates at 2^CW-1 and never wraps.
- R6: Each valid verdict subtracts 1 from fail_count, which stays at 0 when already 0.
- R7: An update that leaves fail_count greater than fail_limit sets ovf_flag in the same cycle as the update. ovf_flag then stays set until flag_clr is high with no such update in that cycle. A setting update wins over flag_clr.
- R8: At most one verdict is given per cycle, each as a one-cycle pulse. When a trigger and a window-ending tick fall in the same cycle, the trigger decides the verdict.
- R9: While enable is low, triggers are ignored, no pulses are given, fail_count holds, and the period is held at the start of the closed window. flag_clr still clears ovf_flag while enable is low.
- R10: Window time advances only on cycles with tick high. Without ticks, no window ever ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Watchdog enable |
| tick | input | 1 | Timer tick strobe |
| trigger | input | 1 | Service trigger strobe |
| closed_len | input | TW | Closed window length in ticks (0 acts as 1) |
| open_len | input | TW | Open window length in ticks (0 acts as 1) |
| fail_limit | input | CW | Overflow limit for the failure counter |
| flag_clr | input | 1 | Clears the overflow flag |
| fail_count | output | CW | Failure counter value |
| ovf_flag | output | 1 | Sticky overflow flag / safe-state request |
| valid_pulse | output | 1 | One-cycle valid-verdict pulse |
| invalid_pulse | output | 1 | One-cycle invalid-verdict pulse |

## Verification
The bench sweeps small window lengths, including zero, and places a trigger at every tick position of both windows. An off-by-one window comparison would move each pulse by a cycle. A trigger placed on the very last tick of a window would give the wrong verdict if the tick were allowed to beat the trigger. It drives the counter into both saturation points: an unguarded add wraps from 30 to 0, and an unguarded subtract wraps from 0 to 31. It also checks the flag against clear-versus-set collisions, against the enable gating that must freeze the period at its start, and against a sparse tick pattern that exposes a timer counting clock cycles instead of ticks.

// File: rtl/win_watchdog.sv
module win_watchdog #(
  parameter int TW = 16,
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          enable,
  input  logic          tick,
  input  logic          trigger,
  input  logic [TW-1:0] closed_len,
  input  logic [TW-1:0] open_len,
  input  logic [CW-1:0] fail_limit,
  input  logic          flag_clr,
  output logic [CW-1:0] fail_count,
  output logic          ovf_flag,
  output logic          valid_pulse,
  output logic          invalid_pulse
);

  localparam logic [CW-1:0] CNT_MAX = '1;

  logic          in_open;
  logic [TW-1:0] tmr;

  logic [TW:0]   tmr_nxt_w;
  logic          closed_done, open_done;
  logic          good_ev, bad_ev;
  logic [CW:0]   sum2;
  logic [CW-1:0] cnt_up, cnt_dn, cnt_nxt;

  assign tmr_nxt_w   = {1'b0, tmr} + 1'b1;
  assign closed_done = tick && !in_open && (tmr_nxt_w >= {1'b0, closed_len});
  assign open_done   = tick &&  in_open && (tmr_nxt_w >= {1'b0, open_len});

  assign good_ev = enable && trigger && in_open;
  assign bad_ev  = enable && ((trigger && !in_open) || (!trigger && open_done));

  assign sum2    = {1'b0, fail_count} + (CW+1)'(2);
  assign cnt_up  = (sum2 > {1'b0, CNT_MAX}) ? CNT_MAX : sum2[CW-1:0];
  assign cnt_dn  = (fail_count == '0) ? '0 : fail_count - 1'b1;
  assign cnt_nxt = bad_ev ? cnt_up : (good_ev ? cnt_dn : fail_count);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_open <= 1'b0;
      tmr     <= '0;
    end else if (!enable || good_ev || bad_ev) begin
      in_open <= 1'b0;
      tmr     <= '0;
    end else if (closed_done) begin
      in_open <= 1'b1;
      tmr     <= '0;
    end else if (tick) begin
      tmr     <= tmr_nxt_w[TW-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fail_count    <= '0;
      ovf_flag      <= 1'b0;
      valid_pulse   <= 1'b0;
      invalid_pulse <= 1'b0;
    end else begin
      fail_count    <= cnt_nxt;
      valid_pulse   <= good_ev;
      invalid_pulse <= bad_ev;
      if ((good_ev || bad_ev) && (cnt_nxt > fail_limit))
        ovf_flag <= 1'b1;
      else if (flag_clr)
        ovf_flag <= 1'b0;
    end
  end

endmodule

// File: rtl/win_watchdog_chk.sv
module win_watchdog_chk #(
  parameter int CW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          enable,
  input logic          flag_clr,
  input logic [CW-1:0] fail_limit,
  input logic [CW-1:0] fail_count,
  input logic          ovf_flag,
  input logic          valid_pulse,
  input logic          invalid_pulse
);

  localparam logic [CW-1:0] TOP = '1;

  logic [CW-1:0] prev_cnt;
  logic [CW:0]   prev_plus2;
  logic [CW-1:0] exp_up, exp_dn;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_cnt <= '0;
    else        prev_cnt <= fail_count;
  end

  assign prev_plus2 = {1'b0, prev_cnt} + (CW+1)'(2);
  assign exp_up     = (prev_plus2 > {1'b0, TOP}) ? TOP : prev_plus2[CW-1:0];
  assign exp_dn     = (prev_cnt == '0) ? '0 : prev_cnt - 1'b1;

  p_one_event_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_pulse && invalid_pulse));

  p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_pulse || invalid_pulse) |=> !(valid_pulse || invalid_pulse));

  p_add_two_r5: assert property (@(posedge clk) disable iff (!rst_n)
    invalid_pulse |-> fail_count == exp_up);

  p_sub_one_r6: assert property (@(posedge clk) disable iff (!rst_n)
    valid_pulse |-> fail_count == exp_dn);

  p_hold_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_pulse || invalid_pulse) |-> fail_count == prev_cnt);

  p_flag_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf_flag && !flag_clr) |=> ovf_flag);

  p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((valid_pulse || invalid_pulse) && fail_count > $past(fail_limit)) |-> ovf_flag);

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !(valid_pulse || invalid_pulse));

endmodule

bind win_watchdog win_watchdog_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .flag_clr(flag_clr),
  .fail_limit(fail_limit), .fail_count(fail_count), .ovf_flag(ovf_flag),
  .valid_pulse(valid_pulse), .invalid_pulse(invalid_pulse)
);

// File: tb/test_win_watchdog.sv
`timescale 1ns/1ps
module test_win_watchdog;
  localparam int TW = 8;
  localparam int CW = 5;

  logic clk = 0, rst_n = 0, enable = 0, tick = 0, trigger = 0, flag_clr = 0;
  logic [TW-1:0] closed_len = 1, open_len = 1;
  logic [CW-1:0] fail_limit = '1;
  logic [CW-1:0] fail_count;
  logic ovf_flag, valid_pulse, invalid_pulse;

  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  win_watchdog #(.TW(TW), .CW(CW)) i_win_watchdog (
    .clk(clk), .rst_n(rst_n), .enable(enable), .tick(tick), .trigger(trigger),
    .closed_len(closed_len), .open_len(open_len), .fail_limit(fail_limit),
    .flag_clr(flag_clr), .fail_count(fail_count), .ovf_flag(ovf_flag),
    .valid_pulse(valid_pulse), .invalid_pulse(invalid_pulse)
  );

  task automatic expect_eq(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input bit t);
    trigger = t;
    @(posedge clk); #1;
    trigger = 0;
  endtask

  task automatic do_reset();
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    rst_n = 1;
  endtask

  task automatic run_to_event(output int n, output bit inv);
    n = 0;
    do begin
      step(0);
      n++;
    end while (!valid_pulse && !invalid_pulse && n < 300);
    inv = invalid_pulse;
  endtask

  function automatic int atleast1(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int n;
    bit inv;
    enable = 1; tick = 1;

    // R1 reset state
    closed_len = 2; open_len = 2;
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1;
    expect_eq("R1 count in reset", int'(fail_count), 0);
    rst_n = 1;
    expect_eq("R1 flag", int'(ovf_flag), 0);
    expect_eq("R1 pulses", int'(valid_pulse) + int'(invalid_pulse), 0);
    step(0);
    expect_eq("R1 count after release", int'(fail_count), 0);

    // R2 timeout spacing, lengths 0..4 / 0..3
    for (int c = 0; c <= 4; c++) begin
      for (int o = 0; o <= 3; o++) begin
        closed_len = TW'(c); open_len = TW'(o); fail_limit = '1;
        do_reset();
        run_to_event(n, inv);
        expect_eq("R2 first timeout cycles", n, atleast1(c) + atleast1(o));
        expect_eq("R2 timeout is invalid", int'(inv), 1);
        expect_eq("R5 count after one invalid", int'(fail_count), 2);
        step(0);
        expect_eq("R8 pulse lasts one cycle", int'(invalid_pulse), 0);
        run_to_event(n, inv);
        expect_eq("R2 second timeout cycles", n + 1, atleast1(c) + atleast1(o));
        expect_eq("R5 count after two invalids", int'(fail_count), 4);
      end
    end

    // R4 valid trigger at every open position (last one collides with final tick, R8)
    for (int c = 1; c <= 3; c++) begin
      for (int o = 1; o <= 3; o++) begin
        for (int p = 0; p < o; p++) begin
          closed_len = TW'(c); open_len = TW'(o); fail_limit = '1;
          do_reset();
          run_to_event(n, inv);
          for (int k = 0; k < c; k++) step(0);
          for (int k = 0; k < p; k++) step(0);
          expect_eq("R4 no event before trigger", int'(valid_pulse) + int'(invalid_pulse), 0);
          step(1);
          expect_eq("R4 open trigger valid", int'(valid_pulse), 1);
          expect_eq("R8 open trigger not invalid", int'(invalid_pulse), 0);
          expect_eq("R6 count after valid", int'(fail_count), 1);
          run_to_event(n, inv);
          expect_eq("R4 new closed window after valid", n, c + o);
        end
      end
    end

    // R3 trigger at every closed position (last one collides with closing tick, R8)
    for (int c = 1; c <= 4; c++) begin
      for (int q = 0; q < c; q++) begin
        closed_len = TW'(c); open_len = 2; fail_limit = '1;
        do_reset();
        for (int k = 0; k < q; k++) step(0);
        step(1);
        expect_eq("R3 closed trigger invalid", int'(invalid_pulse), 1);
        expect_eq("R3 closed trigger not valid", int'(valid_pulse), 0);
        expect_eq("R5 count after closed trigger", int'(fail_count), 2);
        run_to_event(n, inv);
        expect_eq("R3 closed window restarts", n, c + 2);
      end
    end

    // R6 floor at zero
    closed_len = 1; open_len = 1; fail_limit = '1;
    do_reset();
    step(0);
    step(1);
    expect_eq("R6 valid pulse at zero", int'(valid_pulse), 1);
    expect_eq("R6 count stays zero", int'(fail_count), 0);

    // R5 ceiling at 31, no flag with limit 31
    do_reset();
    for (int k = 1; k <= 17; k++) begin
      run_to_event(n, inv);
      expect_eq("R5 saturating count", int'(fail_count), (2*k > 31) ? 31 : 2*k);
    end
    expect_eq("R7 flag with limit at max", int'(ovf_flag), 0);

    // R7 overflow flag
    fail_limit = 5;
    do_reset();
    run_to_event(n, inv);
    run_to_event(n, inv);
    expect_eq("R7 flag at count 4", int'(ovf_flag), 0);
    run_to_event(n, inv);
    expect_eq("R7 count 6", int'(fail_count), 6);
    expect_eq("R7 flag set above limit", int'(ovf_flag), 1);
    step(0); step(1);
    step(0); step(1);
    expect_eq("R7 count after two valids", int'(fail_count), 4);
    expect_eq("R7 flag sticky", int'(ovf_flag), 1);
    flag_clr = 1;
    step(0);
    expect_eq("R7 flag cleared", int'(ovf_flag), 0);
    step(0);
    expect_eq("R7 count 6 with clear held", int'(fail_count), 6);
    expect_eq("R7 set wins over clear", int'(ovf_flag), 1);
    flag_clr = 0;

    // R9 enable gating
    closed_len = 2; open_len = 2; fail_limit = 1;
    do_reset();
    run_to_event(n, inv);
    expect_eq("R9 flag before gating", int'(ovf_flag), 1);
    step(0); step(0); step(0);
    enable = 0;
    for (int k = 0; k < 10; k++) begin
      step(k % 2 == 0);
      expect_eq("R9 no pulse while off", int'(valid_pulse) + int'(invalid_pulse), 0);
      expect_eq("R9 count holds while off", int'(fail_count), 2);
    end
    flag_clr = 1;
    step(0);
    flag_clr = 0;
    expect_eq("R9 clear works while off", int'(ovf_flag), 0);
    enable = 1;
    run_to_event(n, inv);
    expect_eq("R9 period restarts at closed start", n, 4);

    // R10 tick gating
    closed_len = 2; open_len = 1; fail_limit = '1;
    tick = 0;
    do_reset();
    for (int k = 0; k < 20; k++) step(0);
    expect_eq("R10 no event without ticks", int'(fail_count), 0);
    n = -1;
    for (int k = 0; k < 30 && n < 0; k++) begin
      tick = (k % 3 == 0);
      step(0);
      if (invalid_pulse) n = k;
    end
    tick = 1;
    expect_eq("R10 event after three ticks", n, 6);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule